// File: doc/BRIEF.md
# Strided Disk Register Bridge

This block connects a 4 KiB memory-mapped window to the register set of a disk task-file interface. On that interface the registers are 16 bytes apart instead of packed. An access arrives on a simple bus with a valid, a write enable, a size code, an address and write data. The bridge works out which register the access reaches. It then raises a read or write strobe toward the register side in the same cycle. For reads, it returns the answer one cycle later, registered.

Byte accesses reach the seven command registers and the control/status register. The control/status register appears at two places in the window. Halfword and word accesses reach only the data port. The byte order is reversed on the way in and on the way out, so a host with the other byte order sees a natural data stream. Any location that is not mapped reads back as all ones and ignores writes.

Top module: `ide_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Address bits [3:0] and all bits above bit 11 have no effect on routing.
- R2: A byte access (size code 0) at index 1 to 7 gives `reg_idx` equal to that index. A write puts the byte on `reg_wdata[7:0]` with the upper bits zero. A read returns `{24'h0, reg_rdata[7:0]}`.
- R3: A byte access at index 8 or index 22 gives `reg_idx` = 8, the control/status select. A write strobes the control register, and a read returns the status byte from `reg_rdata[7:0]`.
- R4: A byte access at any other index, index 0 included, raises no strobe. A read of such a location returns `32'h0000_00FF`.
- R5: A halfword access (size code 1) at index 0 reaches the data port (`reg_idx` = 0, `reg_word` = 0). Write data goes out as `{16'h0, wdata[7:0], wdata[15:8]}`. A read returns `{16'h0, reg_rdata[7:0], reg_rdata[15:8]}`.
- R6: A word access (size code 2) at index 0 reaches the data port with `reg_word` = 1. The four bytes are reversed in both directions.
- R7: A halfword or word access at a nonzero index raises no strobe. A read returns `32'h0000_FFFF` for a halfword and `32'hFFFF_FFFF` for a word.
- R8: Size code 3 is reserved. It raises no strobe, and a read returns `32'hFFFF_FFFF`.
- R9: Every read raises `bus_rvalid` for exactly the following cycle, with its data on `bus_rdata`. Writes and idle cycles leave `bus_rvalid` low and `bus_rdata` unchanged.
- R10: After reset, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R11: Strobes go out only for mapped locations. `reg_rd` follows a bus read and `reg_wr` follows a bus write, never both at once. `reg_wdata` is zero unless `reg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| reg_idx | output | 4 | 0 data port, 1-7 command registers, 8 control/status |
| reg_wr | output | 1 | Write strobe to register side |
| reg_rd | output | 1 | Read strobe to register side |
| reg_word | output | 1 | Data-port access is a word (else halfword) |
| reg_wdata | output | 32 | Write data toward registers, byte-swapped for data port |
| reg_rdata | input | 32 | Register read data, valid in the strobe cycle |

## Verification
The strobes, index and write data toward the register side are combinational, so they are due in the same cycle as the request. The bench checks them a nanosecond after it drives the inputs on the falling edge. Read data and its valid flag pass through one register, so they are due on the rising edge that follows the request. A behavioural model in the bench updates its expected values on that same edge, and the outputs are compared with it on every falling edge. Between reads, the model holds its last value, which checks that the data does not change.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam logic [3:0] SEL_DATA = 4'd0;
    localparam logic [3:0] SEL_CTL  = 4'd8;

    typedef struct packed {
        logic        hit;
        logic [3:0]  sel;
        logic        word;
        logic [31:0] fill;
    } route_t;

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
    } bridge_state_t;

endpackage

// File: rtl/ide_bridge_decode.sv
module ide_bridge_decode
    import ide_bridge_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int WIN_BITS     = 12,
    parameter int STRIDE_SHIFT = 4,
    parameter int TF_LAST      = 7,
    parameter int CTL_ALIAS_A  = 8,
    parameter int CTL_ALIAS_B  = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output route_t            route
);
    localparam int IDX_W = WIN_BITS - STRIDE_SHIFT;

    logic [IDX_W-1:0] idx;
    logic             is_tf;
    logic             is_ctl;
    logic             is_zero;

    assign idx     = addr[WIN_BITS-1:STRIDE_SHIFT];
    assign is_tf   = (int'(idx) >= 1) && (int'(idx) <= TF_LAST);
    assign is_ctl  = (int'(idx) == CTL_ALIAS_A) || (int'(idx) == CTL_ALIAS_B);
    assign is_zero = (idx == '0);

    always_comb begin
        route      = '0;
        route.sel  = SEL_DATA;
        route.fill = 32'hFFFF_FFFF;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                route.fill = 32'h0000_00FF;
                if (is_tf) begin
                    route.hit = 1'b1;
                    route.sel = 4'(idx);
                end else if (is_ctl) begin
                    route.hit = 1'b1;
                    route.sel = SEL_CTL;
                end
            end
            SZ_HALF: begin
                route.fill = 32'h0000_FFFF;
                route.hit  = is_zero;
            end
            SZ_WORD: begin
                route.hit  = is_zero;
                route.word = is_zero;
            end
            default: begin
                route.hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ide_bridge_swap.sv
module ide_bridge_swap #(
    parameter int LANES = 4
) (
    input  logic                 word,
    input  logic [8*LANES-1:0]   din,
    output logic [8*LANES-1:0]   dout
);
    localparam int HALF_LANES = LANES / 2;

    logic [8*LANES-1:0] full_rev;
    logic [8*LANES-1:0] half_rev;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_full
            assign full_rev[8*g +: 8] = din[8*(LANES-1-g) +: 8];
        end
        for (g = 0; g < HALF_LANES; g++) begin : g_half
            assign half_rev[8*g +: 8] = din[8*(HALF_LANES-1-g) +: 8];
        end
        for (g = HALF_LANES; g < LANES; g++) begin : g_half_pad
            assign half_rev[8*g +: 8] = 8'h00;
        end
    endgenerate

    assign dout = word ? full_rev : half_rev;

endmodule

// File: rtl/ide_bridge.sv
module ide_bridge
    import ide_bridge_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int WIN_BITS     = 12,
    parameter int STRIDE_SHIFT = 4,
    parameter int TF_LAST      = 7,
    parameter int CTL_ALIAS_A  = 8,
    parameter int CTL_ALIAS_B  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [3:0]        reg_idx,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              reg_word,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);
    localparam int LANES = 4;

    route_t        route;
    logic [31:0]   wr_swapped;
    logic [31:0]   rd_swapped;
    logic          is_byte;
    bridge_state_t st_d;
    bridge_state_t st_q;

    ide_bridge_decode #(
        .ADDR_W      (ADDR_W),
        .WIN_BITS    (WIN_BITS),
        .STRIDE_SHIFT(STRIDE_SHIFT),
        .TF_LAST     (TF_LAST),
        .CTL_ALIAS_A (CTL_ALIAS_A),
        .CTL_ALIAS_B (CTL_ALIAS_B)
    ) i_decode (
        .addr (bus_addr),
        .size (bus_size),
        .route(route)
    );

    ide_bridge_swap #(.LANES(LANES)) i_swap_wr (
        .word(route.word),
        .din (bus_wdata),
        .dout(wr_swapped)
    );

    ide_bridge_swap #(.LANES(LANES)) i_swap_rd (
        .word(route.word),
        .din (reg_rdata),
        .dout(rd_swapped)
    );

    assign is_byte = (acc_size_e'(bus_size) == SZ_BYTE);

    always_comb begin
        reg_idx   = route.hit ? route.sel : SEL_DATA;
        reg_rd    = bus_valid && !bus_we && route.hit;
        reg_wr    = bus_valid &&  bus_we && route.hit;
        reg_word  = route.hit && route.word;
        reg_wdata = '0;
        if (reg_wr) begin
            reg_wdata = is_byte ? {24'h0, bus_wdata[7:0]} : wr_swapped;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_valid && !bus_we;
        if (bus_valid && !bus_we) begin
            if (!route.hit) begin
                st_d.rdata = route.fill;
            end else if (is_byte) begin
                st_d.rdata = {24'h0, reg_rdata[7:0]};
            end else begin
                st_d.rdata = rd_swapped;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rvalid = st_q.rvalid;
    assign bus_rdata  = st_q.rdata;

    // R9
    read_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |=> bus_rvalid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> (!bus_rvalid && $stable(bus_rdata)));

    // R11
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R11
    strobe_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> bus_valid);

    // R7
    wide_offset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !is_byte && (bus_addr[WIN_BITS-1:STRIDE_SHIFT] != '0)) |-> !(reg_rd || reg_wr));

    // R3
    ctl_alias_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && is_byte && ((int'(bus_addr[WIN_BITS-1:STRIDE_SHIFT]) == CTL_ALIAS_A) ||
                                  (int'(bus_addr[WIN_BITS-1:STRIDE_SHIFT]) == CTL_ALIAS_B)))
        |-> ((reg_idx == SEL_CTL) && (reg_rd || reg_wr)));

    // R8
    rsvd_size_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_size == 2'd3)) |-> !(reg_rd || reg_wr));

    // R5
    data_port_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rd || reg_wr) && (reg_idx == SEL_DATA)) |-> !is_byte);

endmodule

// File: tb/test_ide_bridge.sv
`timescale 1ns/1ps
module test_ide_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [3:0]  reg_idx;
    logic        reg_wr;
    logic        reg_rd;
    logic        reg_word;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    logic        exp_rvalid;
    logic [31:0] exp_rdata;

    always #2 clk = ~clk;

    ide_bridge i_ide_bridge (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .reg_idx(reg_idx),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int slot(input logic [31:0] a);
        return int'(a[11:4]);
    endfunction

    function automatic bit exp_hit(input logic [1:0] sz, input logic [31:0] a);
        int i = slot(a);
        if (sz == 2'd0) return (i >= 1 && i <= 7) || i == 8 || i == 22;
        if (sz == 2'd1 || sz == 2'd2) return i == 0;
        return 1'b0;
    endfunction

    function automatic logic [3:0] exp_sel(input logic [31:0] a);
        int i = slot(a);
        if (i >= 1 && i <= 7) return 4'(i);
        if (i == 8 || i == 22) return 4'd8;
        return 4'd0;
    endfunction

    function automatic logic [31:0] flip(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd1) return {16'h0, d[7:0], d[15:8]};
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [31:0] a,
                                             input logic [31:0] src);
        if (exp_hit(sz, a)) return (sz == 2'd0) ? {24'h0, src[7:0]} : flip(sz, src);
        if (sz == 2'd0) return 32'h0000_00FF;
        if (sz == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // behavioural reference for the registered read path
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_rvalid <= 1'b0;
            exp_rdata  <= '0;
        end else begin
            exp_rvalid <= bus_valid && !bus_we;
            if (bus_valid && !bus_we) exp_rdata <= exp_read(bus_size, bus_addr, reg_rdata);
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R9", "bus_rvalid", 32'(bus_rvalid), 32'(exp_rvalid));
            check("R9", "bus_rdata", bus_rdata, exp_rdata);
        end
    end

    task automatic op(input string tag, input bit we, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] wd, input logic [31:0] src);
        bit h;
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_size = sz; bus_addr = a;
        bus_wdata = wd; reg_rdata = src;
        #1;
        h = exp_hit(sz, a);
        check(tag, "reg_rd", 32'(reg_rd), 32'(h && !we));
        check(tag, "reg_wr", 32'(reg_wr), 32'(h && we));
        if (h) begin
            check(tag, "reg_idx", 32'(reg_idx), 32'(exp_sel(a)));
            check(tag, "reg_word", 32'(reg_word), 32'(sz == 2'd2));
        end
        if (h && we)
            check(tag, "reg_wdata", reg_wdata, (sz == 2'd0) ? {24'h0, wd[7:0]} : flip(sz, wd));
        else
            check("R11", "reg_wdata idle", reg_wdata, 32'h0);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        #1;
        check("R11", "no strobe when idle", 32'(reg_rd || reg_wr), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset rvalid", 32'(bus_rvalid), 32'h0);
        check("R10", "reset rdata", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        for (int i = 1; i <= 7; i++) begin
            op("R2", 1'b1, 2'd0, 32'(i * 16), 32'hABCD_EF00 | 32'(i), 32'h0);
            op("R2", 1'b0, 2'd0, 32'(i * 16), 32'h0, 32'h1234_5600 | 32'(i * 3));
        end
        op("R3", 1'b1, 2'd0, 32'h080, 32'h0000_0006, 32'h0);
        op("R3", 1'b1, 2'd0, 32'h160, 32'h0000_0002, 32'h0);
        op("R3", 1'b0, 2'd0, 32'h080, 32'h0, 32'hFFFF_FF50);
        op("R3", 1'b0, 2'd0, 32'h16C, 32'h0, 32'h0000_0058);
        op("R4", 1'b0, 2'd0, 32'h000, 32'h0, 32'h5A5A_5A5A);
        op("R4", 1'b0, 2'd0, 32'h090, 32'h0, 32'h5A5A_5A5A);
        op("R4", 1'b0, 2'd0, 32'h150, 32'h0, 32'h1111_1111);
        op("R4", 1'b0, 2'd0, 32'hFF0, 32'h0, 32'h1111_1111);
        op("R4", 1'b1, 2'd0, 32'h170, 32'h0000_0077, 32'h0);
        idle();
        op("R5", 1'b1, 2'd1, 32'h000, 32'hDEAD_BEEF, 32'h0);
        op("R5", 1'b0, 2'd1, 32'h00A, 32'h0, 32'hCAFE_1234);
        op("R6", 1'b1, 2'd2, 32'h004, 32'h0102_0304, 32'h0);
        op("R6", 1'b0, 2'd2, 32'h000, 32'h0, 32'hA1B2_C3D4);
        op("R7", 1'b0, 2'd1, 32'h010, 32'h0, 32'h1234_5678);
        op("R7", 1'b0, 2'd2, 32'h160, 32'h0, 32'h1234_5678);
        op("R7", 1'b1, 2'd2, 32'h020, 32'hFFFF_0000, 32'h0);
        op("R8", 1'b0, 2'd3, 32'h000, 32'h0, 32'h0000_0000);
        op("R8", 1'b1, 2'd3, 32'h030, 32'h55AA_55AA, 32'h0);
        op("R1", 1'b0, 2'd0, 32'hABCD_E035, 32'h0, 32'h0000_00C3);
        op("R1", 1'b0, 2'd2, 32'h7777_F00F, 32'h0, 32'h8899_AABB);
        op("R1", 1'b1, 2'd0, 32'h0001_1168, 32'h0000_0004, 32'h0);
        idle();
        idle();
        op("R9", 1'b0, 2'd2, 32'h000, 32'h0, 32'h0F0E_0D0C);
        op("R9", 1'b0, 2'd0, 32'h040, 32'h0, 32'h0000_0033);
        idle();
        idle();
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule